// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single transfer requests from a core into bus cycles on a bus whose low byte carries the address first and the data afterwards. It handles memory reads, memory writes, I/O reads, I/O writes and opcode fetches. Each cycle is made of three bus states. A device that needs more time can stretch a cycle by holding `ready` low, which adds wait states.

The sequencer runs on a clock at twice the bus rate. Each bus state therefore covers two clocks, a first half and a second half. This makes the half-state edges fall on exact clock boundaries: the address strobe falls in the middle of the first state, `ready` is sampled in the middle of the second state, read data is taken in the middle of the third state, and write data is held past the release of the write strobe.

The core holds `req` with its fields for one clock while the sequencer is idle. It then waits for the one-clock `done` pulse. For a read, the captured byte is on `rdata` from that pulse onward.

Top module: `mux_bus_seq`

## Requirements
Clock indices count from 0. Index 0 is the first clock after the edge that accepts a request. With no wait states the transfer occupies indices 0 to 5: the first bus state is 0-1, the second is 2-3 and the third is 4-5.
- R1: A transfer without wait states occupies exactly six clocks. `done` is high only in the last clock (index 5 without waits), and the sequencer is idle in the clock after it.
- R2: `ale` is high only in index 0. In indices 0 and 1, `ad_oe` is 1 and `ad_out` carries the low byte of the address. `a_hi` carries the high byte of the address for the whole transfer.
- R3: `io_m` (1 = I/O, 0 = memory) and `status` become valid in the clock where `ale` is high and stay constant until the end of the transfer. The `status` encoding is 2'b10 for a read, 2'b01 for a write and 2'b11 for an opcode fetch.
- R4: On a read, `ad_oe` is 0 from index 2 onward. `rd_n` is low from index 3 through the last clock of the transfer. `wr_n` stays high.
- R5: On a write, `ad_oe` is 1 and `ad_out` carries the write data from index 2 onward. `wr_n` is low from index 3 through the second-to-last clock and is high again in the last clock, while the data is still driven. `rd_n` stays high.
- R6: `ready` is sampled only at the end of index 2, and at the end of the first clock of each wait state. When it is sampled low, a two-clock wait state follows index 3, and `ale`, `rd_n`, `wr_n`, `ad_oe`, `ad_out`, `a_hi`, `io_m` and `status` keep their values through that wait state.
- R7: On a read, `rdata` takes the value of `ad_in` at the end of the second-to-last clock, half a bus state before `rd_n` rises. A different value on `ad_in` in the last clock does not change `rdata`. Writes leave `rdata` unchanged.
- R8: A request is accepted only at an edge where the sequencer is idle. A request presented during a transfer changes none of that transfer's outputs and starts no transfer of its own.
- R9: An opcode fetch uses read timing and reports status 2'b11, whatever the value of `req_wr`.
- R10: After reset and while idle, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `status`=2'b00, `io_m`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus state rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, taken when idle |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_fetch | input | 1 | Opcode fetch (read timing) |
| done | output | 1 | One-clock end-of-transfer pulse |
| rdata | output | DATA_W | Last captured read byte |
| ready | input | 1 | Device ready, low requests wait states |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | Space select, 1 = I/O |
| status | output | 2 | Cycle kind code |
| ad_out | output | DATA_W | Multiplexed address/data byte driven out |
| ad_oe | output | 1 | Output enable for ad_out |
| ad_in | input | DATA_W | Multiplexed byte seen from the bus |
| a_hi | output | ADDR_W-DATA_W | High address bits |

## Verification
Transfers are run with 0, 1, 2 and 3 wait states across all four space/direction combinations and both kinds of fetch. During these runs, `ready` is pulsed high in clocks that are not sample points: a design that samples at the wrong phase ends the cycle early and is caught. The bus byte is valid only in the capture clock and is inverted one clock later, which separates capture in the middle of the third state from capture at its end. Requests with inverted fields are pushed during some transfers to show that a busy sequencer ignores them. All-zero and all-one addresses and data expose byte swaps between the address phase and the data phase.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     req_wr,
  input  logic                     req_io,
  input  logic                     req_fetch,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  input  logic                     ready,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n,
  output logic                     io_m,
  output logic [1:0]               status,
  output logic [DATA_W-1:0]        ad_out,
  output logic                     ad_oe,
  input  logic [DATA_W-1:0]        ad_in,
  output logic [ADDR_W-DATA_W-1:0] a_hi
);
  localparam int HI_W = ADDR_W - DATA_W;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3} bst_t;

  bst_t              st;
  logic              ph;
  logic              rdy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q, io_q, fetch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= 1'b0;
      rdy_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      fetch_q <= 1'b0;
      rdata   <= '0;
    end else if (st == S_IDLE) begin
      ph <= 1'b0;
      if (req) begin
        st      <= S_T1;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_wr & ~req_fetch;
        io_q    <= req_io;
        fetch_q <= req_fetch;
      end
    end else begin
      ph <= ~ph;
      if (!ph) begin
        if (st == S_T2 || st == S_TW) rdy_q <= ready;
        if (st == S_T3 && !wr_q) rdata <= ad_in;
      end else begin
        case (st)
          S_T1:       st <= S_T2;
          S_T2, S_TW: st <= rdy_q ? S_T3 : S_TW;
          default:    st <= S_IDLE;
        endcase
      end
    end
  end

  logic busy, strobe;
  assign busy   = (st != S_IDLE);
  assign strobe = (st == S_T2 && ph) || st == S_TW || st == S_T3;

  assign ale    = (st == S_T1) && !ph;
  assign io_m   = busy & io_q;
  assign status = !busy ? 2'b00 : fetch_q ? 2'b11 : wr_q ? 2'b01 : 2'b10;
  assign a_hi   = busy ? addr_q[ADDR_W-1 -: HI_W] : '0;
  assign ad_oe  = (st == S_T1) || (busy && wr_q);
  assign ad_out = (st == S_T1) ? addr_q[DATA_W-1:0] : wdata_q;
  assign rd_n   = ~(strobe & ~wr_q);
  assign wr_n   = ~(strobe & wr_q & ~(st == S_T3 && ph));
  assign done   = (st == S_T3) && ph;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_ALE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_STATUS_AT_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (status != 2'b00)); // R3
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> $stable({status, io_m, a_hi})); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R4
  AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe); // R5
  AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TW) |-> $stable({ale, rd_n, wr_n, ad_oe, ad_out, a_hi, io_m, status})); // R6
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rd_n); // R7
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> !ale); // R8
endmodule

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;
  localparam int NT = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req, req_wr, req_io, req_fetch, ready;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, ad_in, rdata, ad_out;
  logic        done, ale, rd_n, wr_n, io_m, ad_oe;
  logic [1:0]  status;
  logic [7:0]  a_hi;

  mux_bus_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wr(req_wr), .req_io(req_io),
    .req_fetch(req_fetch), .done(done), .rdata(rdata), .ready(ready),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .status(status),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi)
  );

  integer total = 0;
  integer bad = 0;

  task automatic chk(input string tag, input string nm,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag, input logic [7:0] er);
    chk(tag, "ale", ale, 0);
    chk(tag, "rd_n", rd_n, 1);
    chk(tag, "wr_n", wr_n, 1);
    chk(tag, "ad_oe", ad_oe, 0);
    chk(tag, "done", done, 0);
    chk(tag, "status", status, 0);
    chk(tag, "io_m", io_m, 0);
    chk("R7", "rdata idle", rdata, er);
  endtask

  logic [15:0] t_addr [NT];
  logic [7:0]  t_wd   [NT];
  logic [7:0]  t_rd   [NT];
  logic        t_wr   [NT];
  logic        t_io   [NT];
  logic        t_fe   [NT];
  int          t_n    [NT];
  logic        t_junk [NT];

  task automatic set_t(input int i, input logic [15:0] a, input logic [7:0] wd,
                       input logic [7:0] rv, input logic w, input logic io,
                       input logic fe, input int n, input logic jk);
    t_addr[i] = a; t_wd[i] = wd; t_rd[i] = rv; t_wr[i] = w; t_io[i] = io;
    t_fe[i] = fe; t_n[i] = n; t_junk[i] = jk;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ti, k, L, gap, cur;
    logic busy, wrf;
    logic [7:0] exp_rdata;
    string tg;

    set_t(0, 16'h1234, 8'h00, 8'hA5, 0, 0, 0, 0, 0);
    set_t(1, 16'h8001, 8'h3C, 8'h00, 1, 0, 0, 0, 0);
    set_t(2, 16'h00F0, 8'h11, 8'h5A, 0, 1, 0, 2, 0);
    set_t(3, 16'hFF0F, 8'hC3, 8'h00, 1, 1, 0, 1, 0);
    set_t(4, 16'h4000, 8'h00, 8'h96, 0, 0, 1, 0, 0);
    set_t(5, 16'h4001, 8'h77, 8'h69, 1, 0, 1, 1, 0);
    set_t(6, 16'h2222, 8'hE1, 8'h00, 1, 0, 0, 3, 1);
    set_t(7, 16'h3333, 8'h44, 8'h0F, 0, 1, 0, 1, 1);
    set_t(8, 16'h0000, 8'h00, 8'hFF, 0, 0, 0, 0, 0);
    set_t(9, 16'hFFFF, 8'hFF, 8'h00, 1, 1, 0, 0, 0);

    rst_n = 0; req = 0; req_addr = 0; req_wdata = 0; req_wr = 0;
    req_io = 0; req_fetch = 0; ready = 0; ad_in = 0;
    exp_rdata = 0;
    repeat (3) begin
      @(negedge clk);
      chk_idle("R10", exp_rdata);
    end
    rst_n = 1;

    ti = 0; k = 0; L = 0; gap = 1; busy = 0; cur = 0; wrf = 0;
    while (ti < NT || busy || gap > 0) begin
      @(negedge clk);
      if (busy) begin
        L = 6 + 2 * t_n[cur];
        wrf = t_wr[cur] & ~t_fe[cur];
        if (t_junk[cur]) tg = "R8";
        else if (k >= 4 && k < L - 2) tg = "R6";
        else if (t_fe[cur]) tg = "R9";
        else tg = wrf ? "R5" : "R4";
        chk(tg, "ale R2", ale, (k == 0));
        chk(tg, "a_hi R2", a_hi, t_addr[cur][15:8]);
        chk(tg, "io_m R3", io_m, t_io[cur]);
        chk(tg, "status R3", status, t_fe[cur] ? 2'b11 : wrf ? 2'b01 : 2'b10);
        chk(tg, "ad_oe", ad_oe, (k < 2) || wrf);
        if (k < 2) chk(tg, "ad_out addr R2", ad_out, t_addr[cur][7:0]);
        else if (wrf) chk(tg, "ad_out data R5", ad_out, t_wd[cur]);
        chk(tg, "rd_n", rd_n, !(!wrf && k >= 3));
        chk(tg, "wr_n", wr_n, !(wrf && k >= 3 && k <= L - 2));
        chk("R1", "done", done, (k == L - 1));
        if (k == L - 1 && !wrf) exp_rdata = t_rd[cur];
        chk("R7", "rdata", rdata, exp_rdata);
        ready = (k >= 2 * t_n[cur] + 2) || (k % 2 == 1);
        ad_in = (k == L - 2) ? t_rd[cur] : ~t_rd[cur];
        if (t_junk[cur]) begin
          req = 1; req_addr = ~t_addr[cur]; req_wdata = ~t_wd[cur];
          req_wr = ~t_wr[cur]; req_io = ~t_io[cur]; req_fetch = 0;
        end else req = 0;
        k = k + 1;
        if (k == L) begin
          busy = 0;
          gap = 1;
        end
      end else begin
        chk_idle((cur > 0 && t_junk[cur]) ? "R8" : "R10", exp_rdata);
        ready = 0;
        ad_in = 8'h5C;
        if (gap > 0 || ti >= NT) begin
          req = 0;
          if (gap > 0) gap = gap - 1;
        end else begin
          req = 1; req_addr = t_addr[ti]; req_wdata = t_wd[ti];
          req_wr = t_wr[ti]; req_io = t_io[ti]; req_fetch = t_fe[ti];
          cur = ti; ti = ti + 1; busy = 1; k = 0;
        end
      end
    end
    repeat (3) begin
      @(negedge clk);
      chk_idle("R8", exp_rdata);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule